// File: doc/BRIEF.md
# Gated Reciprocal Frequency Counter

This block measures the period of a square wave by counting cycles of a fixed reference clock over a window of whole input cycles. The input is synchronized into the reference domain, and only its rising edges matter. A prescaler passes either every rising edge or every tenth one. A loop counter, loaded from the host's preset, counts these prescaled edges. A gate admits reference cycles into a 32-bit reference counter for exactly that many prescaled periods.

The host sets the preset and the prescaler select, then pulses start. The gate does not open at start. It opens on the first prescaled edge that follows. When the last edge of the window arrives, the gate closes and the done flag rises. The count then stays frozen until the next start. The host computes the input frequency from the preset, the prescale factor and the count. A start pulse during a measurement abandons that measurement and begins a fresh one.

Top module: `recip_freq_meter`

## Requirements
- R1: After reset, `done` is 0 and `ref_count` is 0.
- R2: On the clock edge that samples `start` high, the measurement restarts. From the following cycle, `done` is 0 and `ref_count` is 0.
- R3: With `div_sel` = 0 (divide by 1) and a periodic input of period P reference cycles, the final `ref_count` is preset × P.
- R4: With `div_sel` = 1 (divide by 10), the final `ref_count` is preset × P × 10.
- R5: The window begins on the first prescaled rising edge after start. The result is the same whatever the phase of the input at the moment start is applied.
- R6: `done` rises on the cycle the gate closes. While `start` stays low, `done` remains 1 and `ref_count` does not change.
- R7: The reference counter stops at its all-ones value (2^REF_W − 1) and does not wrap.
- R8: A start pulse during an open window aborts that window. The preset present at that pulse is reloaded, and the result matches a fresh measurement with that preset.
- R9: A preset of 0 behaves like a preset of 1, giving a window of one prescaled period.
- R10: Only rising input edges are counted. The duty cycle of the input does not change the result for a given period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Measured square wave, asynchronous to clk |
| div_sel | input | 1 | Prescaler select: 0 passes every rising edge, 1 passes every tenth |
| preset | input | CNT_W | Window length in prescaled input periods, captured at start |
| start | input | 1 | Single-cycle pulse that starts or restarts a measurement |
| done | output | 1 | High once the window has closed, until the next start |
| ref_count | output | REF_W | Reference cycles counted while the gate was open |

## Verification
The restart effect of start is due one cycle after the edge that samples it, so the bench checks a cleared flag and count at the next falling edge. A window's result is complete on the cycle `done` rises, which comes three cycles after the input edge that closes the window (two synchronizer stages plus the gate register). For that reason the bench does not predict the cycle of that edge. It polls `done` at falling edges and then compares `ref_count` with preset × period × prescale, held at the counter's maximum. Tests for frozen results and for abort wait a fixed number of cycles before sampling again, so a late change would show.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
   typedef enum logic [1:0] {
      GS_IDLE  = 2'd0,
      GS_ARMED = 2'd1,
      GS_OPEN  = 2'd2,
      GS_DONE  = 2'd3
   } gate_state_t;

   localparam int unsigned RFM_DIV_HI = 10;
endpackage

// File: rtl/rfm_edge_sync.sv
module rfm_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_async,
   output logic rise
);
   logic [STAGES:0] chain;

   generate
      for (genvar i = 0; i <= STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= sig_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/rfm_prescale.sv
module rfm_prescale #(
   parameter int unsigned DIV_HI = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic div_sel,
   input  logic rise,
   output logic tick
);
   localparam int unsigned PW = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV_HI - 1);

   logic [PW-1:0] pcnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr || !div_sel) pcnt <= '0;
      else if (rise) pcnt <= (pcnt == LAST) ? '0 : pcnt + PW'(1);
   end

   assign tick = div_sel ? (rise && (pcnt == LAST)) : rise;
endmodule

// File: rtl/rfm_gate_ctrl.sv
module rfm_gate_ctrl
   import rfm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] preset,
   input  logic             tick,
   output logic             gate_open,
   output logic             done
);
   gate_state_t      state;
   logic [CNT_W-1:0] loop_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= GS_IDLE;
         loop_cnt <= '0;
      end else if (start) begin
         state    <= GS_ARMED;
         loop_cnt <= preset;
      end else begin
         unique case (state)
            GS_ARMED: if (tick) state <= GS_OPEN;
            GS_OPEN:  if (tick) begin
               if (loop_cnt <= CNT_W'(1)) state <= GS_DONE;
               else                       loop_cnt <= loop_cnt - CNT_W'(1);
            end
            default: ;
         endcase
      end
   end

   assign gate_open = (state == GS_OPEN);
   assign done      = (state == GS_DONE);
endmodule

// File: rtl/rfm_ref_counter.sv
module rfm_ref_counter #(
   parameter int unsigned REF_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   output logic [REF_W-1:0] count
);
   localparam logic [REF_W-1:0] TOP = {REF_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n || clr)            count <= '0;
      else if (en && count != TOP)  count <= count + REF_W'(1);
   end
endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned REF_W       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DIV_HI      = rfm_pkg::RFM_DIV_HI
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sig_in,
   input  logic             div_sel,
   input  logic [CNT_W-1:0] preset,
   input  logic             start,
   output logic             done,
   output logic [REF_W-1:0] ref_count
);
   initial begin
      assert (CNT_W >= 1 && CNT_W <= 32) else $fatal(1, "CNT_W out of range");
      assert (REF_W >= 2 && REF_W <= 64) else $fatal(1, "REF_W out of range");
      assert (SYNC_STAGES >= 2)          else $fatal(1, "SYNC_STAGES below 2");
      assert (DIV_HI >= 2)               else $fatal(1, "DIV_HI below 2");
   end

   logic rise;
   logic tick;
   logic gate_open;

   rfm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sig_async(sig_in), .rise(rise)
   );

   rfm_prescale #(.DIV_HI(DIV_HI)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(start), .div_sel(div_sel),
      .rise(rise), .tick(tick)
   );

   rfm_gate_ctrl #(.CNT_W(CNT_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .start(start), .preset(preset),
      .tick(tick), .gate_open(gate_open), .done(done)
   );

   rfm_ref_counter #(.REF_W(REF_W)) u_ref (
      .clk(clk), .rst_n(rst_n), .clr(start), .en(gate_open),
      .count(ref_count)
   );
endmodule

// File: rtl/recip_freq_meter_chk.sv
module recip_freq_meter_chk #(
   parameter int unsigned REF_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             gate_open,
   input logic             done,
   input logic [REF_W-1:0] ref_count
);
   localparam logic [REF_W-1:0] TOP = {REF_W{1'b1}};

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done && ref_count == '0)); // R2

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(ref_count))); // R6

   AST_GATE_SHUT_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !gate_open); // R6

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_count == TOP && !start) |=> (ref_count == TOP)); // R7

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_open && !start && ref_count != TOP) |=> (ref_count == $past(ref_count) + REF_W'(1))); // R3
endmodule

bind recip_freq_meter recip_freq_meter_chk #(.REF_W(REF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .gate_open(gate_open),
   .done(done), .ref_count(ref_count)
);

// File: tb/recip_freq_meter_bench.sv
`timescale 1ns/1ps
module recip_freq_meter_bench;
   localparam int CW = 8;
   localparam int RW = 12;
   localparam int RMAX = (1 << RW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sig_in = 1'b0;
   logic div_sel = 1'b0;
   logic [CW-1:0] preset = '0;
   logic start = 1'b0;
   logic done;
   logic [RW-1:0] ref_count;

   int checks = 0;
   int errors = 0;
   int hi_len = 2;
   int lo_len = 2;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   recip_freq_meter #(.CNT_W(CW), .REF_W(RW)) u_recip_freq_meter (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .div_sel(div_sel),
      .preset(preset), .start(start), .done(done), .ref_count(ref_count)
   );

   // input waveform generator
   initial begin
      forever begin
         repeat (hi_len) @(negedge clk);
         sig_in = 1'b1;
         repeat (lo_len) @(negedge clk);
         sig_in = 1'b0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_start(input int p, input bit d);
      @(negedge clk);
      preset = CW'(p);
      div_sel = d;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      if (!done) check(req, 0, 1);
   endtask

   function automatic int expect_cnt(input int p, input int per, input bit d);
      int e = ((p == 0) ? 1 : p) * per * (d ? 10 : 1);
      return (e > RMAX) ? RMAX : e;
   endfunction

   task automatic measure(input string req, input int p, input bit d, input int per);
      pulse_start(p, d);
      check("R2 done cleared", int'(done), 0);
      check("R2 count cleared", int'(ref_count), 0);
      wait_done(req);
      check(req, int'(ref_count), expect_cnt(p, per, d));
   endtask

   task automatic set_wave(input int h, input int l);
      hi_len = h;
      lo_len = l;
      repeat (3 * (h + l) + 40) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 done", int'(done), 0);
      check("R1 count", int'(ref_count), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done after release", int'(done), 0);
      check("R1 count after release", int'(ref_count), 0);

      // sweep waveforms, presets (0 covers R9), both prescaler settings
      for (int w = 0; w < 4; w++) begin
         int h = (w == 0) ? 1 : (w == 1) ? 2 : (w == 2) ? 5 : 3;
         int l = (w == 0) ? 2 : (w == 1) ? 2 : (w == 2) ? 2 : 4;
         set_wave(h, l);
         for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 5; p++) begin
               // varying gaps shift start phase (R5); duty differs by w (R10)
               repeat (p + w) @(negedge clk);
               if (p == 0)      measure("R9 zero preset", p, d[0], h + l);
               else if (d == 0) measure("R3 div1 R5 R10", p, d[0], h + l);
               else             measure("R4 div10 R5 R10", p, d[0], h + l);
            end
         end
      end

      // R10: same period, opposite duty, same result
      set_wave(6, 1);
      measure("R10 duty 6/1", 3, 1'b0, 7);
      set_wave(1, 6);
      measure("R10 duty 1/6", 3, 1'b0, 7);

      // R6: frozen result after done
      begin
         int held;
         held = int'(ref_count);
         repeat (200) @(negedge clk);
         check("R6 done held", int'(done), 1);
         check("R6 count frozen", int'(ref_count), held);
      end

      // R8: abort mid-window and reload the new preset
      set_wave(2, 3);
      pulse_start(20, 1'b0);
      repeat (40) @(negedge clk);
      check("R8 still running", int'(done), 0);
      measure("R8 abort reload", 4, 1'b1, 5);

      // R7: saturation (60*8*10 = 4800 > 4095)
      set_wave(4, 4);
      measure("R7 saturate", 60, 1'b1, 8);
      repeat (30) @(negedge clk);
      check("R7 held at max", int'(ref_count), RMAX);

      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule